// File: doc/BRIEF.md
# Mode-Configurable Multiply-Accumulate Unit

This block multiplies two 16-bit operands and either loads the product into a 32-bit accumulator or adds it to or subtracts it from the current accumulator value. A new operation can be issued on every clock. Each operation passes through a two-stage pipeline: the product is formed in the first stage and the accumulator is updated in the second.

A status register controls how the unit works. It holds a 4-bit mode field that selects:

- signed or unsigned operands,
- integer or Q15 fractional interpretation,
- saturation on overflow,
- rounding of the upper accumulator half.

The same register keeps negative, zero and sticky overflow flags.

A small register port reads and writes three registers: status, an address-mask word (stored only) and the accumulator. A rounded view of the accumulator's upper half is also available on its own output. A typical use is a filter tap loop: one load operation followed by back-to-back accumulate operations, with the result read from the accumulator.

Top module: `mac_unit`

## Requirements
- R1: `reg_sel` selects a register: 0 is status, 1 is mask, 2 is the accumulator, and 3 reads as zero. `reg_rdata` shows the selected register combinationally. A write with `reg_we` takes effect at the next rising edge. Reset sets status to 0x0000_0000 and mask to 0xFFFF_FFFF. The accumulator is not reset.
- R2: Status layout:
  - bit 0: V (overflow)
  - bit 1: Z (zero)
  - bit 2: N (negative)
  - bit 4: unsigned
  - bit 5: fractional
  - bit 6: saturate
  - bit 7: round
  
  Bit 3 and bits 31:8 always read zero.
- R3: An operation driven with `op_valid` before rising edge k is visible in the accumulator after rising edge k+1. One operation is accepted every cycle, and back-to-back accumulations chain correctly.
- R4: `op_acc`=0 loads the product into the accumulator. `op_acc`=1 adds it to the accumulator, or subtracts it when `op_sub`=1.
- R5: With the unsigned bit set and the fractional bit clear, operands and the accumulator are unsigned. Otherwise they are two's complement.
- R6: With the fractional bit set, operands are signed Q15 values and the product is doubled (Q31 alignment), whatever the unsigned bit says.
- R7: When the exact result of an operation lies outside the 32-bit range of the active signedness, V is set. V stays set until status is written.
- R8: On overflow with the saturate bit set, the accumulator clamps to the bound nearest the exact result. The bounds are 0x7FFF_FFFF and 0x8000_0000 in signed mode, and 0xFFFF_FFFF and 0 in unsigned mode.
- R9: On overflow without saturation, the accumulator keeps the low 32 bits of the exact result.
- R10: Every accumulator write, from an operation or from the register port, sets N to bit 31 and sets Z when all 32 bits are zero. A status write instead loads all the flags from the written data.
- R11: `acc_hi` shows accumulator bits 31:16. When both the fractional and round bits are set, it shows (accumulator + 0x8000) bits 31:16 instead, held at 0x7FFF if a positive value would wrap.
- R12: A register-port write to the accumulator in the same cycle as a pipeline result takes priority over the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | asynchronous reset, active low |
| reg_we | input | 1 | register write strobe |
| reg_sel | input | 2 | register select |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | selected register value |
| op_valid | input | 1 | issue an operation this cycle |
| op_acc | input | 1 | 1 accumulates, 0 loads the product |
| op_sub | input | 1 | subtract the product when accumulating |
| op_a | input | 16 | first operand |
| op_b | input | 16 | second operand |
| acc_hi | output | 16 | upper accumulator half, optionally rounded |

## Verification
The bench builds the unit with its default widths of 16-bit operands and a 32-bit accumulator, so a 64-bit integer model in the bench holds every exact result. That size lets it run all sixteen mode codes against every pair of eight corner operands (0, 1, all ones, the largest positive value, the most negative value and three mid-range patterns), streamed back to back with loads, additions and subtractions. This mix drives both signed and unsigned overflow into clamping and into wrap-around. A four-tap fractional FIR, directed rounding values around 0x8000, and a collision between a register write and a pipeline result complete the run.

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int OPW  = 16,
  parameter int ACCW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [1:0]      reg_sel,
  input  logic [ACCW-1:0] reg_wdata,
  output logic [ACCW-1:0] reg_rdata,
  input  logic            op_valid,
  input  logic            op_acc,
  input  logic            op_sub,
  input  logic [OPW-1:0]  op_a,
  input  logic [OPW-1:0]  op_b,
  output logic [ACCW/2-1:0] acc_hi
);
  localparam int PW = 2*OPW + 2;
  localparam int SW = (PW > ACCW ? PW : ACCW) + 2;
  localparam int HW = ACCW/2;
  localparam logic [1:0] SEL_STAT = 2'd0, SEL_MASK = 2'd1, SEL_ACC = 2'd2;
  localparam logic [ACCW-1:0] SMAX = {1'b0, {(ACCW-1){1'b1}}};
  localparam logic [ACCW-1:0] SMIN = {1'b1, {(ACCW-1){1'b0}}};

  logic [7:0]      stat_q;
  logic [ACCW-1:0] mask_q, acc_q;

  wire m_uns  = stat_q[4];
  wire m_frac = stat_q[5];
  wire m_sat  = stat_q[6];
  wire m_rnd  = stat_q[7];
  wire is_signed = !m_uns || m_frac;

  wire wr_stat = reg_we && reg_sel == SEL_STAT;
  wire wr_mask = reg_we && reg_sel == SEL_MASK;
  wire wr_acc  = reg_we && reg_sel == SEL_ACC;

  // stage 1: product
  logic signed [OPW:0]  ea, eb;
  logic signed [PW-1:0] prod, p1_q;
  logic v1_q, acc1_q, sub1_q;

  assign ea   = {is_signed & op_a[OPW-1], op_a};
  assign eb   = {is_signed & op_b[OPW-1], op_b};
  assign prod = m_frac ? (PW'(ea * eb) <<< 1) : PW'(ea * eb);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) v1_q <= 1'b0;
    else        v1_q <= op_valid;

  always_ff @(posedge clk)
    if (op_valid) begin
      p1_q   <= prod;
      acc1_q <= op_acc;
      sub1_q <= op_sub;
    end

  // stage 2: accumulate
  logic signed [SW-1:0] base, addend, sum;
  logic                 ovf;
  logic [ACCW-1:0]      res;

  assign base   = !acc1_q ? '0 :
                  is_signed ? {{(SW-ACCW){acc_q[ACCW-1]}}, acc_q}
                            : {{(SW-ACCW){1'b0}}, acc_q};
  assign addend = {{(SW-PW){p1_q[PW-1]}}, p1_q};
  assign sum    = sub1_q ? base - addend : base + addend;
  assign ovf    = is_signed ? !(&sum[SW-1:ACCW-1] || !(|sum[SW-1:ACCW-1]))
                            : |sum[SW-1:ACCW];

  always_comb begin
    res = sum[ACCW-1:0];
    if (ovf && m_sat)
      res = is_signed ? (sum[SW-1] ? SMIN : SMAX)
                      : (sum[SW-1] ? '0 : '1);
  end

  always_ff @(posedge clk)
    if (wr_acc)    acc_q <= reg_wdata;
    else if (v1_q) acc_q <= res;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      if (wr_mask) mask_q <= reg_wdata;
      if (wr_stat)
        stat_q <= {reg_wdata[7:4], 1'b0, reg_wdata[2:0]};
      else if (wr_acc)
        stat_q[2:1] <= {reg_wdata[ACCW-1], reg_wdata == '0};
      else if (v1_q)
        stat_q[2:0] <= {res[ACCW-1], res == '0, stat_q[0] | ovf};
    end

  always_comb
    case (reg_sel)
      SEL_STAT: reg_rdata = {{(ACCW-8){1'b0}}, stat_q};
      SEL_MASK: reg_rdata = mask_q;
      SEL_ACC:  reg_rdata = acc_q;
      default:  reg_rdata = '0;
    endcase

  // rounded upper half
  logic [HW-1:0] rnd_t;
  assign rnd_t  = acc_q[ACCW-1:HW] + HW'(acc_q[HW-1]);
  assign acc_hi = !(m_frac && m_rnd) ? acc_q[ACCW-1:HW] :
                  (!acc_q[ACCW-1] && rnd_t[HW-1]) ? {1'b0, {(HW-1){1'b1}}} : rnd_t;

  // R1
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q));
  // R3
  acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!v1_q && !wr_acc) |=> $stable(acc_q));
  // R7
  v_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[0] && !wr_stat) |=> stat_q[0]);
  // R8
  sat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v1_q && ovf && m_sat && !wr_acc) |=>
      (acc_q == SMAX || acc_q == SMIN || acc_q == '0 || acc_q == '1));
  // R10
  nz_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((v1_q || wr_acc) && !wr_stat) |=>
      (stat_q[1] == (acc_q == '0) && stat_q[2] == acc_q[ACCW-1]));
  // R2
  stat_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel == SEL_STAT |-> reg_rdata[ACCW-1:8] == '0 && !reg_rdata[3]);
endmodule

// File: tb/tb_mac_unit.sv
`timescale 1ns/1ps
module tb_mac_unit;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0, op_valid = 0, op_acc = 0, op_sub = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [15:0] op_a = 0, op_b = 0, acc_hi;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  mac_unit dut (.clk, .rst_n, .reg_we, .reg_sel, .reg_wdata, .reg_rdata,
                .op_valid, .op_acc, .op_sub, .op_a, .op_b, .acc_hi);

  // reference state
  logic [7:0]  m_mode = 0;
  logic [31:0] m_acc = 0;
  bit          m_v = 0;
  bit          pv [2];
  logic [31:0] pacc [2];
  logic [2:0]  pflg [2];
  string       ptag [2];

  task automatic chk(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    reg_sel = sel; #0.1; v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  function automatic void model(input logic [15:0] a, b, input bit accum, sub);
    bit uns = m_mode[4] && !m_mode[5];
    longint pa = uns ? longint'({48'b0, a}) : longint'($signed(a));
    longint pb = uns ? longint'({48'b0, b}) : longint'($signed(b));
    longint p = pa * pb;
    longint bs = !accum ? 0 : uns ? longint'({32'b0, m_acc}) : longint'($signed(m_acc));
    longint s;
    bit o;
    if (m_mode[5]) p = p * 2;
    s = sub ? bs - p : bs + p;
    o = uns ? (s < 0 || s > 64'sh0FFFF_FFFF) : (s > 64'sh7FFF_FFFF || s < -64'sh8000_0000);
    if (o) m_v = 1;
    if (o && m_mode[6]) m_acc = uns ? (s < 0 ? 32'h0 : 32'hFFFF_FFFF) : (s < 0 ? 32'h8000_0000 : 32'h7FFF_FFFF);
    else m_acc = s[31:0];
  endfunction

  // one cycle of the stream: check result from two cycles back, then drive
  task automatic cyc(input bit vld, input logic [15:0] a, b, input bit accum, sub, input string tag);
    logic [31:0] r;
    @(negedge clk);
    if (pv[1]) begin
      rd(2'd2, r); chk({ptag[1], " acc"}, r, pacc[1]);
      rd(2'd0, r); chk({ptag[1], " R10 flags"}, {29'b0, r[2:0]}, {29'b0, pflg[1]});
    end
    pv[1] = pv[0]; pacc[1] = pacc[0]; pflg[1] = pflg[0]; ptag[1] = ptag[0];
    op_valid = vld; op_a = a; op_b = b; op_acc = accum; op_sub = sub;
    if (vld) begin
      model(a, b, accum, sub);
      pv[0] = 1; pacc[0] = m_acc; pflg[0] = {m_acc[31], m_acc == 0, m_v}; ptag[0] = tag;
    end else pv[0] = 0;
  endtask

  task automatic flush();
    cyc(0, 0, 0, 0, 0, ""); cyc(0, 0, 0, 0, 0, ""); cyc(0, 0, 0, 0, 0, "");
  endtask

  task automatic set_mode(input logic [7:0] md);
    wr(2'd0, {24'b0, md}); m_mode = md; m_v = 0;
    wr(2'd2, 0); m_acc = 0;
  endtask

  logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
                            16'h8000, 16'h1234, 16'hABCD, 16'h0003};
  logic [15:0] cf [4] = '{16'h4000, 16'h2000, 16'hE000, 16'h1000};
  logic [15:0] xs [8] = '{16'h1000, 16'h7000, 16'h9000, 16'h0100,
                          16'hF000, 16'h4000, 16'h8000, 16'h2345};

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    pv[0] = 0; pv[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values and map
    rd(2'd0, r); chk("R1 status reset", r, 32'h0);
    rd(2'd1, r); chk("R1 mask reset", r, 32'hFFFF_FFFF);
    rd(2'd3, r); chk("R1 unused select", r, 32'h0);
    wr(2'd1, 32'h1357_9BDF);
    rd(2'd1, r); chk("R1 mask write", r, 32'h1357_9BDF);
    // R2 status layout
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, r); chk("R2 status pad bits", r, 32'h0000_00F7);
    wr(2'd0, 0);
    rd(2'd0, r); chk("R2 status clear", r, 32'h0);

    // R3 R4 R5 R6 R7 R8 R9 sweep over all modes and corner operands
    for (int md = 0; md < 16; md++) begin
      flush();
      set_mode(8'(md << 4));
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          int k = (i + j) % 4;
          cyc(1, vals[i], vals[j], k != 0, k == 2, $sformatf("R4 R5 R6 R8 R9 mode %0d", md));
        end
      flush();
    end

    // R3 R6 four-tap FIR in Q15, back to back
    set_mode(8'h20);
    for (int n = 3; n < 8; n++)
      for (int t = 0; t < 4; t++)
        cyc(1, cf[t], xs[n-t], t != 0, 0, "R3 R6 fir");
    flush();
    begin
      longint s = 0;
      for (int t = 0; t < 4; t++) s += 2 * longint'($signed(cf[t])) * longint'($signed(xs[7-t]));
      rd(2'd2, r); chk("R3 R6 fir direct sum", r, s[31:0]);
    end

    // R7 V sticky across a clean op, cleared by status write
    set_mode(8'h00);
    cyc(1, 16'h7FFF, 16'h7FFF, 0, 0, "R7 load");
    cyc(1, 16'h7FFF, 16'h7FFF, 1, 0, "R7 add");
    cyc(1, 16'h7FFF, 16'h7FFF, 1, 0, "R7 overflow");
    cyc(1, 16'h0001, 16'h0001, 0, 0, "R7 sticky");
    flush();
    rd(2'd0, r); chk("R7 V still set", {31'b0, r[0]}, 32'd1);
    wr(2'd0, 0);
    rd(2'd0, r); chk("R7 V cleared", {31'b0, r[0]}, 32'd0);

    // R10 register writes update N and Z
    wr(2'd2, 32'h0);
    rd(2'd0, r); chk("R10 Z on acc write", {29'b0, r[2:0]}, 32'd2);
    wr(2'd2, 32'h8000_0000);
    rd(2'd0, r); chk("R10 N on acc write", {29'b0, r[2:0]}, 32'd4);

    // R11 rounding of the upper half
    wr(2'd0, 32'hA0);
    wr(2'd2, 32'h1234_8000); chk("R11 round up", {16'b0, acc_hi}, 32'h1235);
    wr(2'd2, 32'h1234_7FFF); chk("R11 round down", {16'b0, acc_hi}, 32'h1234);
    wr(2'd2, 32'h7FFF_8000); chk("R11 round clamp", {16'b0, acc_hi}, 32'h7FFF);
    wr(2'd2, 32'hFFFF_8000); chk("R11 negative", {16'b0, acc_hi}, 32'h0000);
    wr(2'd0, 32'h20);
    wr(2'd2, 32'h1234_FFFF); chk("R11 truncate no round", {16'b0, acc_hi}, 32'h1234);
    wr(2'd0, 32'h80);
    chk("R11 truncate integer", {16'b0, acc_hi}, 32'h1234);

    // R12 register write beats pipeline result
    wr(2'd0, 0);
    @(negedge clk); op_valid = 1; op_acc = 0; op_sub = 0; op_a = 16'd5; op_b = 16'd7;
    @(negedge clk); op_valid = 0; reg_we = 1; reg_sel = 2'd2; reg_wdata = 32'hCAFE_0001;
    @(negedge clk); reg_we = 0;
    rd(2'd2, r); chk("R12 write priority", r, 32'hCAFE_0001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule